// File: doc/BRIEF.md
# Display controller CPU register port

This block is the processor side of a character-based display controller. It decodes a 16-bit I/O port address and holds a 5-bit register index plus eighteen internal byte registers. It carries out register writes and returns read data. The stored register values drive the video timing block, which is outside this block.

What a read returns depends on a 3-bit variant input. That input selects one of five read behaviours. The behaviours differ in which registers can be read back, what unused indexes return, whether a status byte exists, and whether the index is folded to three bits on reads.

The processor has no read/write direction line at this port. Any strobe on the index or data-write function therefore stores the byte on the write bus. Read data is combinational from the address, the held index and the variant. Writes, index loads and status flag updates take effect at the clock edge that samples the strobe.

Top module: `vdc_cpu_port`

## Requirements
- R1: The block responds only when `port_addr[14]` is 0. While bit 14 is 1, `rd_data` is 0 and no strobe changes the index or any register.
- R2: Function code `port_addr[9:8]` = 00 with either strobe loads `wr_data[4:0]` into the index at the next clock edge.
- R3: Function 01 with either strobe writes `wr_data` into the register named by the index, masked to that register's width. Indexes 4, 6 and 7 keep 7 bits. Indexes 5, 9, 10 and 11 keep 5 bits. Indexes 12 and 14 keep 6 bits. Indexes 0 to 3, 8, 13 and 15 keep 8 bits. Writes to index 16 and above change nothing.
- R4: A read strobe on function 00 or 01 acts exactly like a write strobe.
- R5: With variant 0, 1 or 2, a function-11 read of indexes 0 to 11 returns 0. With any variant, functions 00 and 01 read 0.
- R6: Variant 0 reads indexes 12 to 17 back on function 11. Indexes 18 to 31 read 0, and function 10 reads 0.
- R7: Variants 1 and 2 read indexes 14 to 17 on function 11, and indexes 12 and 13 read 0. Variant 1 returns FF for index 31 and 0 for indexes 18 to 30. Variant 2 returns 0 for indexes 18 to 31. Variant 2 function 10 reads 0.
- R8: On variant 1, function 10 returns a status byte. Bit 6 is a light-pen flag. The flag is set by `lpen_strobe`. It is cleared by a read strobe on a read of register 16 or 17. When both happen in the same cycle, the set wins.
- R9: Status bit 5 is set when `row_count` is at least the stored index-6 value, and cleared when `row_count` is 0; the clear wins. All other status bits read 0.
- R10: On variants 3 and 4, functions 10 and 11 both read a register chosen by index bits 2:0. The mapping is 0 to register 16, 1 to 17, 2 to 10, 3 to 11, 4 to 12, 5 to 13, 6 to 14 and 7 to 15.
- R11: Reset clears the index, every register and both status flags.
- R12: Variant codes 5 to 7 behave as variant 0.
- R13: The register outputs present the stored values. `start_addr` is {index 12 [5:0], index 13}, and `cursor_addr` is {index 14 [5:0], index 15}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant | input | 3 | Read behaviour select, 0 to 4 (5 to 7 act as 0) |
| port_addr | input | 16 | I/O port address |
| wr_data | input | 8 | Processor data byte |
| rd_strobe | input | 1 | Processor I/O read cycle |
| wr_strobe | input | 1 | Processor I/O write cycle |
| lpen_strobe | input | 1 | Light-pen strobe |
| row_count | input | 7 | Current character row count from the timing block |
| rd_data | output | 8 | Read data, combinational |
| h_total | output | 8 | Register 0 |
| h_displayed | output | 8 | Register 1 |
| h_sync_pos | output | 8 | Register 2 |
| sync_widths | output | 8 | Register 3 |
| v_total | output | 7 | Register 4 |
| v_adjust | output | 5 | Register 5 |
| v_displayed | output | 7 | Register 6 |
| v_sync_pos | output | 7 | Register 7 |
| mode_skew | output | 8 | Register 8 |
| max_raster | output | 5 | Register 9 |
| cursor_start | output | 5 | Register 10 |
| cursor_end | output | 5 | Register 11 |
| start_addr | output | 14 | Registers 12 and 13 joined |
| cursor_addr | output | 14 | Registers 14 and 15 joined |

## Verification
Read data has no register on its path. It is due in the same cycle that the address, index and variant are applied. The bench therefore drives at the falling clock edge and compares 1 ns later, before the next rising edge.

An index load, a register write or a status flag change lands on the one rising edge that samples the strobe or row count. The bench drops its strobes at the following falling edge and only then reads the result back through function 10 or 11. Status sequences apply each `row_count` and `lpen_strobe` value for exactly one edge, so every expected status byte follows from a known count of edges.

// File: rtl/vdc_pkg.sv
package vdc_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned ROW_W    = 7;
  localparam int unsigned NUM_REGS = 18;
  localparam int unsigned WRITABLE = 16;
  localparam int unsigned VAR_W    = 3;

  typedef enum logic [1:0] {
    FN_INDEX = 2'b00,
    FN_WRITE = 2'b01,
    FN_AUX   = 2'b10,
    FN_READ  = 2'b11
  } bus_fn_e;

  // storage width mask per register number
  function automatic logic [DATA_W-1:0] reg_mask(input int unsigned n);
    case (n)
      4, 6, 7:       reg_mask = 8'h7F;
      5, 9, 10, 11:  reg_mask = 8'h1F;
      12, 14:        reg_mask = 8'h3F;
      default:       reg_mask = (n < WRITABLE) ? 8'hFF : 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/vdc_bus_decode.sv
module vdc_bus_decode
  import vdc_pkg::*;
(
  input  logic [15:0] port_addr,
  input  logic        rd_strobe,
  input  logic        wr_strobe,
  output logic        sel,
  output bus_fn_e     fn,
  output logic        idx_load,
  output logic        data_load,
  output logic        any_strobe
);
  wire unused_addr_bits = ^{port_addr[15], port_addr[13:10], port_addr[7:0]};

  always_comb begin
    sel        = ~port_addr[14];
    fn         = bus_fn_e'(port_addr[9:8]);
    any_strobe = sel & (rd_strobe | wr_strobe);
    // no direction line: either strobe stores on the two write functions
    idx_load   = any_strobe & (fn == FN_INDEX);
    data_load  = any_strobe & (fn == FN_WRITE);
  end
endmodule

// File: rtl/vdc_reg_store.sv
module vdc_reg_store
  import vdc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       idx_load,
  input  logic                       data_load,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [IDX_W-1:0]           index_q,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        index_q <= '0;
    else if (idx_load) index_q <= wr_data[IDX_W-1:0];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g < WRITABLE) begin : g_rw
      localparam logic [DATA_W-1:0] MASK = reg_mask(g);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (data_load && index_q == IDX_W'(g))
          q <= wr_data & MASK;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = q;
    end else begin : g_ro
      // read-only capture registers hold their cleared value here
      assign regs_flat[g*DATA_W +: DATA_W] = '0;
    end
  end
endmodule

// File: rtl/vdc_status.sv
module vdc_status
  import vdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lpen_strobe,
  input  logic             lpen_clear,
  input  logic [ROW_W-1:0] row_count,
  input  logic [ROW_W-1:0] v_displayed,
  output logic             lpen_flag,
  output logic             vblank_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lpen_flag <= 1'b0;
    else if (lpen_strobe) lpen_flag <= 1'b1;
    else if (lpen_clear)  lpen_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       vblank_flag <= 1'b0;
    else if (row_count == '0)         vblank_flag <= 1'b0;
    else if (row_count >= v_displayed) vblank_flag <= 1'b1;
  end
endmodule

// File: rtl/vdc_read_mux.sv
module vdc_read_mux
  import vdc_pkg::*;
(
  input  logic [VAR_W-1:0]           variant,
  input  logic                       sel,
  input  bus_fn_e                    fn,
  input  logic [IDX_W-1:0]           index_q,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  input  logic                       lpen_flag,
  input  logic                       vblank_flag,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       lpen_addr_hit
);
  logic [VAR_W-1:0] var_eff;
  logic             folded;
  logic [IDX_W-1:0] eff_reg;
  logic             reg_path;
  logic             readable;

  always_comb begin
    var_eff = (variant > VAR_W'(4)) ? '0 : variant;
    folded  = (var_eff == VAR_W'(3)) || (var_eff == VAR_W'(4));

    // register number actually addressed by a read
    if (folded)
      eff_reg = (index_q[2:0] < 3'd2) ? IDX_W'(16) + IDX_W'(index_q[2:0])
                                      : IDX_W'(8)  + IDX_W'(index_q[2:0]);
    else
      eff_reg = index_q;

    reg_path = sel && ((fn == FN_READ) || (folded && fn == FN_AUX));

    if (folded)
      readable = 1'b1;
    else if (eff_reg >= IDX_W'(14) && eff_reg <= IDX_W'(17))
      readable = 1'b1;
    else if (var_eff == '0 && (eff_reg == IDX_W'(12) || eff_reg == IDX_W'(13)))
      readable = 1'b1;
    else
      readable = 1'b0;

    rd_data = '0;
    if (reg_path) begin
      if (readable)
        rd_data = regs_flat[eff_reg*DATA_W +: DATA_W];
      else if (var_eff == VAR_W'(1) && index_q == IDX_W'(31))
        rd_data = 8'hFF;
    end else if (sel && fn == FN_AUX && var_eff == VAR_W'(1)) begin
      rd_data = {1'b0, lpen_flag, vblank_flag, 5'b0};
    end

    lpen_addr_hit = reg_path && (eff_reg == IDX_W'(16) || eff_reg == IDX_W'(17));
  end
endmodule

// File: rtl/vdc_cpu_port.sv
module vdc_cpu_port
  import vdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  variant,
  input  logic [15:0] port_addr,
  input  logic [7:0]  wr_data,
  input  logic        rd_strobe,
  input  logic        wr_strobe,
  input  logic        lpen_strobe,
  input  logic [6:0]  row_count,
  output logic [7:0]  rd_data,
  output logic [7:0]  h_total,
  output logic [7:0]  h_displayed,
  output logic [7:0]  h_sync_pos,
  output logic [7:0]  sync_widths,
  output logic [6:0]  v_total,
  output logic [4:0]  v_adjust,
  output logic [6:0]  v_displayed,
  output logic [6:0]  v_sync_pos,
  output logic [7:0]  mode_skew,
  output logic [4:0]  max_raster,
  output logic [4:0]  cursor_start,
  output logic [4:0]  cursor_end,
  output logic [13:0] start_addr,
  output logic [13:0] cursor_addr
);
  logic                       sel;
  bus_fn_e                    fn;
  logic                       idx_load;
  logic                       data_load;
  logic                       any_strobe;
  logic [IDX_W-1:0]           index_q;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic                       lpen_flag;
  logic                       vblank_flag;
  logic                       lpen_addr_hit;

  vdc_bus_decode u_dec (
    .port_addr (port_addr),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .sel       (sel),
    .fn        (fn),
    .idx_load  (idx_load),
    .data_load (data_load),
    .any_strobe(any_strobe)
  );

  vdc_reg_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_load (idx_load),
    .data_load(data_load),
    .wr_data  (wr_data),
    .index_q  (index_q),
    .regs_flat(regs_flat)
  );

  vdc_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .lpen_strobe(lpen_strobe),
    .lpen_clear (rd_strobe & lpen_addr_hit),
    .row_count  (row_count),
    .v_displayed(v_displayed),
    .lpen_flag  (lpen_flag),
    .vblank_flag(vblank_flag)
  );

  vdc_read_mux u_mux (
    .variant      (variant),
    .sel          (sel),
    .fn           (fn),
    .index_q      (index_q),
    .regs_flat    (regs_flat),
    .lpen_flag    (lpen_flag),
    .vblank_flag  (vblank_flag),
    .rd_data      (rd_data),
    .lpen_addr_hit(lpen_addr_hit)
  );

  wire unused_strobe_or = any_strobe;

  always_comb begin
    h_total      = regs_flat[0*8 +: 8];
    h_displayed  = regs_flat[1*8 +: 8];
    h_sync_pos   = regs_flat[2*8 +: 8];
    sync_widths  = regs_flat[3*8 +: 8];
    v_total      = regs_flat[4*8 +: 7];
    v_adjust     = regs_flat[5*8 +: 5];
    v_displayed  = regs_flat[6*8 +: 7];
    v_sync_pos   = regs_flat[7*8 +: 7];
    mode_skew    = regs_flat[8*8 +: 8];
    max_raster   = regs_flat[9*8 +: 5];
    cursor_start = regs_flat[10*8 +: 5];
    cursor_end   = regs_flat[11*8 +: 5];
    start_addr   = {regs_flat[12*8 +: 6], regs_flat[13*8 +: 8]};
    cursor_addr  = {regs_flat[14*8 +: 6], regs_flat[15*8 +: 8]};
  end
endmodule

// File: rtl/vdc_port_checker.sv
module vdc_port_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  variant,
  input logic [15:0] port_addr,
  input logic [7:0]  wr_data,
  input logic        rd_strobe,
  input logic        wr_strobe,
  input logic        lpen_strobe,
  input logic [6:0]  row_count,
  input logic [7:0]  rd_data,
  input logic [6:0]  v_total,
  input logic [4:0]  index_q,
  input logic        lpen_flag,
  input logic        vblank_flag
);
  logic sel, strobe;
  assign sel    = ~port_addr[14];
  assign strobe = rd_strobe | wr_strobe;

  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    port_addr[14] |-> rd_data == 8'h00);

  a_r1_deselect_hold: assert property (@(posedge clk) disable iff (!rst_n)
    port_addr[14] |=> $stable(index_q) && $stable(v_total));

  a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && port_addr[9:8] == 2'b00 && strobe) |=> index_q == $past(wr_data[4:0]));

  a_r3_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && port_addr[9:8] == 2'b01 && strobe && index_q == 5'd4)
      |=> v_total == $past(wr_data[6:0]));

  a_r7_dummy_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (variant == 3'd1 && sel && port_addr[9:8] == 2'b11 && index_q == 5'd31)
      |-> rd_data == 8'hFF);

  a_r8_lpen_set: assert property (@(posedge clk) disable iff (!rst_n)
    lpen_strobe |=> lpen_flag);

  a_r9_vblank_clear: assert property (@(posedge clk) disable iff (!rst_n)
    row_count == 7'd0 |=> !vblank_flag);

  a_r9_status_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (variant == 3'd1 && sel && port_addr[9:8] == 2'b10)
      |-> rd_data[7] == 1'b0 && rd_data[4:0] == 5'd0);
endmodule

bind vdc_cpu_port vdc_port_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .variant    (variant),
  .port_addr  (port_addr),
  .wr_data    (wr_data),
  .rd_strobe  (rd_strobe),
  .wr_strobe  (wr_strobe),
  .lpen_strobe(lpen_strobe),
  .row_count  (row_count),
  .rd_data    (rd_data),
  .v_total    (v_total),
  .index_q    (index_q),
  .lpen_flag  (lpen_flag),
  .vblank_flag(vblank_flag)
);

// File: tb/vdc_cpu_port_tb_top.sv
`timescale 1ns/1ps
module vdc_cpu_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  variant = 3'd0;
  logic [15:0] port_addr = 16'hFFFF;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_strobe = 1'b0;
  logic        wr_strobe = 1'b0;
  logic        lpen_strobe = 1'b0;
  logic [6:0]  row_count = 7'd0;
  logic [7:0]  rd_data;
  logic [7:0]  h_total, h_displayed, h_sync_pos, sync_widths, mode_skew;
  logic [6:0]  v_total, v_displayed, v_sync_pos;
  logic [4:0]  v_adjust, max_raster, cursor_start, cursor_end;
  logic [13:0] start_addr, cursor_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [0:17];
  logic e_lp = 1'b0;
  logic e_vb = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vdc_cpu_port dut_i (
    .clk(clk), .rst_n(rst_n), .variant(variant), .port_addr(port_addr),
    .wr_data(wr_data), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .lpen_strobe(lpen_strobe), .row_count(row_count), .rd_data(rd_data),
    .h_total(h_total), .h_displayed(h_displayed), .h_sync_pos(h_sync_pos),
    .sync_widths(sync_widths), .v_total(v_total), .v_adjust(v_adjust),
    .v_displayed(v_displayed), .v_sync_pos(v_sync_pos), .mode_skew(mode_skew),
    .max_raster(max_raster), .cursor_start(cursor_start), .cursor_end(cursor_end),
    .start_addr(start_addr), .cursor_addr(cursor_addr)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] fn_addr(input int fn);
    return 16'hBC00 | 16'(fn << 8);
  endfunction

  function automatic logic [7:0] width_mask(input int r);
    if (r == 4 || r == 6 || r == 7) return 8'h7F;
    if (r == 5 || r == 9 || r == 10 || r == 11) return 8'h1F;
    if (r == 12 || r == 14) return 8'h3F;
    if (r < 16) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_rd(input int v, input int fn, input int idx);
    int ve;
    int r;
    ve = (v > 4) ? 0 : v;
    if (fn < 2) return 8'h00;
    if (ve == 3 || ve == 4) begin
      r = idx % 8;
      r = (r < 2) ? 16 + r : 8 + r;
      return model[r];
    end
    if (fn == 2) return (ve == 1) ? {1'b0, e_lp, e_vb, 5'b0} : 8'h00;
    if (idx >= 14 && idx <= 17) return model[idx];
    if (ve == 0 && (idx == 12 || idx == 13)) return model[idx];
    if (ve == 1 && idx == 31) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input bit use_rd);
    @(negedge clk);
    port_addr = a; wr_data = d;
    if (use_rd) rd_strobe = 1'b1; else wr_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; wr_strobe = 1'b0; port_addr = 16'hFFFF;
  endtask

  task automatic write_reg(input int idx, input logic [7:0] val, input bit use_rd);
    bus(fn_addr(0), 8'(idx), use_rd);
    bus(fn_addr(1), val, use_rd);
    if (idx < 16) model[idx] = val & width_mask(idx);
  endtask

  task automatic look(input int fn);
    @(negedge clk);
    port_addr = fn_addr(fn);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 18; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: cleared state after reset
    look(3);
    chk("R11 rd_data idx0", {8'h0, rd_data}, 16'h0);
    chk("R11 start_addr", {2'b0, start_addr}, 16'h0);
    chk("R11 h_total", {8'h0, h_total}, 16'h0);
    variant = 3'd1;
    look(2);
    chk("R11 status", {8'h0, rd_data}, 16'h0);

    // sweep: each variant, write all indexes, read back all functions
    for (int v = 0; v < 8; v++) begin
      if (v == 6) continue;
      variant = 3'(v);
      for (int idx = 0; idx < 32; idx++)
        write_reg(idx, 8'((idx * 37 + v * 53 + 8'hA5) & 8'hFF), (idx % 2) == 1);  // R4 alternate strobes
      // R3 / R13 outputs
      chk("R3 v_total", {9'h0, v_total}, {8'h0, model[4]});
      chk("R3 v_adjust", {11'h0, v_adjust}, {8'h0, model[5]});
      chk("R3 max_raster", {11'h0, max_raster}, {8'h0, model[9]});
      chk("R13 start_addr", {2'b0, start_addr}, {2'b0, model[12][5:0], model[13]});
      chk("R13 cursor_addr", {2'b0, cursor_addr}, {2'b0, model[14][5:0], model[15]});
      chk("R13 mode_skew", {8'h0, mode_skew}, {8'h0, model[8]});
      for (int idx = 0; idx < 32; idx++) begin
        bus(fn_addr(0), 8'(idx), 1'b0);  // R2 index load
        for (int fn = 0; fn < 4; fn++) begin
          look(fn);
          // R5 R6 R7 R10 R12 read visibility
          chk($sformatf("R5/R6/R7/R10/R12 v%0d fn%0d idx%0d", v, fn, idx),
              {8'h0, rd_data}, {8'h0, exp_rd(v, fn, idx)});
        end
      end
    end

    // R1: deselected accesses change nothing and read 0
    variant = 3'd0;
    write_reg(14, 8'h2B, 1'b0);
    bus(16'hFD00, 8'h99, 1'b0);
    bus(16'hFC00, 8'h03, 1'b1);
    @(negedge clk); port_addr = 16'hFF00; #1;
    chk("R1 deselected read", {8'h0, rd_data}, 16'h0);
    look(3);
    chk("R1 register untouched", {8'h0, rd_data}, {8'h0, model[14]});

    // R8 / R9 status on variant 1
    variant = 3'd1;
    write_reg(6, 8'd25, 1'b0);
    @(negedge clk); row_count = 7'd30;
    @(negedge clk); row_count = 7'd10;
    look(2);
    chk("R9 vblank set", {8'h0, rd_data}, 16'h0020);
    @(negedge clk); row_count = 7'd0;
    @(negedge clk); row_count = 7'd5;
    look(2);
    chk("R9 vblank cleared", {8'h0, rd_data}, 16'h0000);
    @(negedge clk); lpen_strobe = 1'b1;
    @(negedge clk); lpen_strobe = 1'b0;
    look(2);
    chk("R8 lpen set", {8'h0, rd_data}, 16'h0040);
    bus(fn_addr(0), 8'd16, 1'b0);
    bus(fn_addr(3), 8'h00, 1'b1);
    look(2);
    chk("R8 cleared by idx16 read", {8'h0, rd_data}, 16'h0000);
    @(negedge clk);
    port_addr = fn_addr(3); rd_strobe = 1'b1; lpen_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; lpen_strobe = 1'b0; port_addr = 16'hFFFF;
    look(2);
    chk("R8 set wins over clear", {8'h0, rd_data}, 16'h0040);
    bus(fn_addr(3), 8'h00, 1'b0);  // wr strobe on read function: no clear
    look(2);
    chk("R8 write strobe no clear", {8'h0, rd_data}, 16'h0040);
    write_reg(6, 8'd0, 1'b0);
    @(negedge clk); row_count = 7'd0;
    @(negedge clk); row_count = 7'd0;
    look(2);
    chk("R9 clear wins at row 0", {8'h0, rd_data}, 16'h0040);
    @(negedge clk); row_count = 7'd3;
    @(negedge clk); row_count = 7'd3;
    look(2);
    chk("R9 set with limit 0", {8'h0, rd_data}, 16'h0060);
    bus(fn_addr(0), 8'd17, 1'b0);
    bus(fn_addr(3), 8'h00, 1'b1);
    look(2);
    chk("R8 cleared by idx17 read", {8'h0, rd_data}, 16'h0020);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule